// File: doc/BRIEF.md
# Pin-Change and Edge Interrupt Detector

This block watches five external interrupt pins that are not synchronous to the processor clock. One pin is a dedicated external-interrupt line. The other four are port-change lines. Each pin is brought into the processor clock domain. Every rising transition and every falling transition then sets its own sticky capture bit for that pin.

The captures drive two interrupt triggers. The external trigger follows either the rising or the falling capture of the dedicated pin, chosen by a select input. The change trigger is the OR of all eight captures that belong to the four change pins. Each trigger leaves the block through a flip-flop on the processor clock. The processor clears the captures one pin at a time with a five-bit clear vector. If an edge arrives in the same cycle as its clear, the edge wins, so no event is lost.

Pins are sampled, so a pulse must stay stable for at least two clock periods to be seen. The sampled pin level resets low. A pin that is already high when reset ends therefore records a rising edge.

Top module: `pin_edge_irq`

## Requirements
- R1: While `rst_n` is low, every capture bit and both trigger flops are cleared, so `ext_irq` and `chg_irq` read 0.
- R2: Each pin has a rising capture bit and a falling capture bit that are set independently. A capture bit stays set until that pin's clear bit is asserted.
- R3: When `ext_rise_sel` is 1, `ext_irq` follows the rising capture of `ext_pin`. When it is 0, `ext_irq` follows the falling capture.
- R4: `chg_irq` is the OR of the rising and falling captures of all four `chg_pins` bits, whichever direction the edge took.
- R5: A one-cycle pulse on `clr[i]` clears both captures of one pin only, and leaves the other pins untouched. Bit 0 of `clr` selects `ext_pin`, and bit k (k = 1 to 4) selects `chg_pins[k-1]`. The affected trigger reads 0 after the second rising clock edge that follows the clear.
- R6: If a new edge on a pin is detected in the same cycle that its clear bit is high, the capture stays set.
- R7: After a pin transition that falls between clock edges, the matching trigger rises at the fourth rising clock edge that follows the transition, and not earlier. This delay comes from two synchronizer stages, one capture register and one output flop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ext_pin | input | 1 | Dedicated external interrupt pin, asynchronous |
| chg_pins | input | 4 | Port-change interrupt pins, asynchronous |
| ext_rise_sel | input | 1 | 1: external trigger on the rising edge; 0: on the falling edge |
| clr | input | 5 | Per-pin clear of both captures (bit 0 is the external pin) |
| ext_irq | output | 1 | Registered external interrupt trigger |
| chg_irq | output | 1 | Registered OR of all change-pin captures |

## Verification
A capture bit that is lost or that sticks wrongly shows at the ports within two clock edges. The trigger either drops while its pin was never cleared, or stays high after its clear. A clear that reaches the wrong pin makes a trigger that should have stayed high go low. A wrong synchronizer depth moves the trigger rise off the fourth clock edge after a transition, so the edge-exact latency checks catch it. Pairing rising and falling events with both settings of the select exposes a mixed-up pair of captures, because the external trigger then reads high under only one of the select values.

// File: rtl/pin_edge_irq.sv
module pin_edge_irq #(
  parameter int CHG_PINS = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ext_pin,
  input  logic [CHG_PINS-1:0] chg_pins,
  input  logic                ext_rise_sel,
  input  logic [CHG_PINS:0]   clr,
  output logic                ext_irq,
  output logic                chg_irq
);
  localparam int NP = CHG_PINS + 1;

  logic [NP-1:0] pins;
  logic [NP-1:0] sync_a, sync_b, lvl;
  logic [NP-1:0] rise_ev, fall_ev;
  logic [NP-1:0] rise_q, fall_q;
  logic          ext_raw, chg_raw;

  assign pins = {chg_pins, ext_pin};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_a <= '0;
      sync_b <= '0;
      lvl    <= '0;
    end else begin
      sync_a <= pins;
      sync_b <= sync_a;
      lvl    <= sync_b;
    end
  end

  assign rise_ev = sync_b & ~lvl;
  assign fall_ev = ~sync_b & lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rise_q <= '0;
      fall_q <= '0;
    end else begin
      rise_q <= (rise_q & ~clr) | rise_ev;
      fall_q <= (fall_q & ~clr) | fall_ev;
    end
  end

  assign ext_raw = ext_rise_sel ? rise_q[0] : fall_q[0];
  assign chg_raw = |(rise_q[NP-1:1] | fall_q[NP-1:1]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_irq <= 1'b0;
      chg_irq <= 1'b0;
    end else begin
      ext_irq <= ext_raw;
      chg_irq <= chg_raw;
    end
  end
endmodule

// File: rtl/pin_edge_irq_chk.sv
module pin_edge_irq_chk #(
  parameter int NP = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic [NP-1:0] clr,
  input logic [NP-1:0] rise_ev,
  input logic [NP-1:0] fall_ev,
  input logic [NP-1:0] rise_q,
  input logic [NP-1:0] fall_q,
  input logic          ext_irq,
  input logic          chg_irq
);
  always @(posedge clk) begin
    if (!rst_n) begin
      AST_RESET_QUIET: assert (!ext_irq && !chg_irq); // R1
    end
  end

  AST_CAPTURE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (|(rise_q & ~clr)) |=> ((rise_q & $past(rise_q & ~clr)) == $past(rise_q & ~clr))); // R2

  AST_EXT_HAS_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ext_irq) |-> $past(rise_q[0] | fall_q[0])); // R3

  AST_CHG_DROP_NEEDS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(chg_irq) |-> $past(|clr[NP-1:1], 2)); // R4

  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr & ~rise_ev & ~fall_ev)) |=>
      (((rise_q | fall_q) & $past(clr & ~rise_ev & ~fall_ev)) == '0)); // R5

  AST_EDGE_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (|rise_ev) |=> ((rise_q & $past(rise_ev)) == $past(rise_ev))); // R6
endmodule

bind pin_edge_irq pin_edge_irq_chk #(.NP(NP)) chk_i (
  .clk(clk), .rst_n(rst_n), .clr(clr), .rise_ev(rise_ev), .fall_ev(fall_ev),
  .rise_q(rise_q), .fall_q(fall_q), .ext_irq(ext_irq), .chg_irq(chg_irq)
);

// File: tb/pin_edge_irq_tb_top.sv
module pin_edge_irq_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ext_pin = 1'b0;
  logic [3:0] chg_pins = '0;
  logic       ext_rise_sel = 1'b1;
  logic [4:0] clr = '0;
  logic       ext_irq, chg_irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  pin_edge_irq dut_i (
    .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .chg_pins(chg_pins),
    .ext_rise_sel(ext_rise_sel), .clr(clr), .ext_irq(ext_irq), .chg_irq(chg_irq)
  );

  always #10 clk = ~clk;

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  // {pins[4:0] (bit0 = ext_pin), clr[4:0], sel, exp_ext, exp_chg}
  localparam int NSTEP = 15;
  localparam logic [12:0] TBL [NSTEP] = '{
    {5'b00001, 5'b00000, 1'b1, 1'b1, 1'b0},
    {5'b00000, 5'b00000, 1'b1, 1'b1, 1'b0},
    {5'b00000, 5'b00001, 1'b1, 1'b0, 1'b0},
    {5'b00010, 5'b00000, 1'b1, 1'b0, 1'b1},
    {5'b00010, 5'b00010, 1'b1, 1'b0, 1'b0},
    {5'b00000, 5'b00000, 1'b0, 1'b0, 1'b1},
    {5'b00001, 5'b00010, 1'b0, 1'b0, 1'b0},
    {5'b00000, 5'b00000, 1'b0, 1'b1, 1'b0},
    {5'b00000, 5'b00000, 1'b1, 1'b1, 1'b0},
    {5'b10100, 5'b00001, 1'b1, 1'b0, 1'b1},
    {5'b10100, 5'b00100, 1'b1, 1'b0, 1'b1},
    {5'b10100, 5'b10000, 1'b1, 1'b0, 1'b0},
    {5'b01000, 5'b00000, 1'b1, 1'b0, 1'b1},
    {5'b01000, 5'b11100, 1'b1, 1'b0, 1'b0},
    {5'b01000, 5'b00000, 1'b0, 1'b0, 1'b0}
  };

  initial begin
    int cyc = 0;
    while (!done && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset ext_irq", ext_irq, 1'b0);
    chk("R1 reset chg_irq", chg_irq, 1'b0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // Table steps: R2 R3 R4 R5
    for (int i = 0; i < NSTEP; i++) begin
      @(posedge clk);
      #(3 + 2 * (i % 4));
      {chg_pins, ext_pin} = TBL[i][12:8];
      ext_rise_sel = TBL[i][2];
      @(negedge clk);
      clr = TBL[i][7:3];
      @(negedge clk);
      clr = '0;
      repeat (5) @(negedge clk);
      chk($sformatf("R2 R3 step %0d ext_irq", i), ext_irq, TBL[i][1]);
      chk($sformatf("R4 R5 step %0d chg_irq", i), chg_irq, TBL[i][0]);
    end

    // R7: latency of the change trigger
    @(negedge clk);
    clr = 5'b11111;
    @(negedge clk);
    clr = '0;
    repeat (3) @(negedge clk);
    @(posedge clk);
    #5 chg_pins[0] = 1'b1;
    @(posedge clk); @(posedge clk); @(posedge clk);
    #1 chk("R7 chg_irq low after third edge", chg_irq, 1'b0);
    @(posedge clk);
    #1 chk("R7 chg_irq high after fourth edge", chg_irq, 1'b1);

    // R7 + R3: latency of the external trigger on a falling edge
    ext_rise_sel = 1'b0;
    @(negedge clk);
    ext_pin = 1'b1;
    repeat (6) @(negedge clk);
    chk("R3 rise ignored with falling select", ext_irq, 1'b0);
    @(posedge clk);
    #13 ext_pin = 1'b0;
    @(posedge clk); @(posedge clk); @(posedge clk);
    #1 chk("R7 ext_irq low after third edge", ext_irq, 1'b0);
    @(posedge clk);
    #1 chk("R7 ext_irq high after fourth edge", ext_irq, 1'b1);

    // R5: a clear drops its trigger after the second edge
    @(negedge clk);
    clr = 5'b00001;
    @(posedge clk);
    #1 clr = '0;
    chk("R5 ext_irq still high after first edge", ext_irq, 1'b1);
    @(posedge clk);
    #1 chk("R5 ext_irq low after second edge", ext_irq, 1'b0);
    chk("R5 chg_irq kept by other pin", chg_irq, 1'b1);

    // R6: clear in the same cycle as a new edge
    ext_rise_sel = 1'b1;
    @(negedge clk);
    clr = 5'b11111;
    @(negedge clk);
    clr = '0;
    repeat (3) @(negedge clk);
    chk("R6 precondition ext_irq", ext_irq, 1'b0);
    @(posedge clk);
    #6 ext_pin = 1'b1;
    @(posedge clk);
    @(posedge clk);
    #1 clr = 5'b00001;
    @(posedge clk);
    #1 clr = '0;
    repeat (3) @(negedge clk);
    chk("R6 edge wins over clear", ext_irq, 1'b1);

    // R1: reset clears held captures
    @(negedge clk);
    ext_pin = 1'b0;
    chg_pins = '0;
    repeat (6) @(negedge clk);
    chk("R1 pre-reset chg_irq set", chg_irq, 1'b1);
    rst_n = 1'b0;
    #1 chk("R1 reset drops ext_irq", ext_irq, 1'b0);
    chk("R1 reset drops chg_irq", chg_irq, 1'b0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk("R1 captures gone after reset ext", ext_irq, 1'b0);
    chk("R1 captures gone after reset chg", chg_irq, 1'b0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule